// File: doc/BRIEF.md
# Per-core local interrupt router

This block gathers the local interrupt sources of a four-core cluster and steers each one to a core's normal interrupt line (IRQ) or its fast interrupt line (FIQ). Each core has four timer requests and four mailbox-active levels. Per-core control registers enable each of these sources onto IRQ, onto FIQ, or onto neither. One shared GPU interrupt is steered to exactly one selected core. A PMU interrupt is gated per core through a pair of write-one-to-set and write-one-to-clear registers.

Each core has two read-only pending words, one for IRQ and one for FIQ. They show which gated sources are active at that moment. A core's output line is the OR of its pending word. Software configures the block through a simple synchronous write port and reads it through a combinational read port. All configuration is zero after reset, so no source reaches any core until it is enabled.

Top module: `lirq_router`

## Requirements
- R1: After reset every configuration register reads zero, and `irq_o` and `fiq_o` stay low whatever the source inputs are.
- R2: The timer control register for core c is at 0x40+4c. Bit k of [3:0] enables timer k of that core onto IRQ, and bit k of [7:4] enables it onto FIQ. The register reads back what was written.
- R3: The mailbox control register for core c is at 0x50+4c. Its layout is the same as R2 but applies to mailbox k of that core, and it reads back what was written.
- R4: When both the IRQ and FIQ enables of a timer or mailbox source are set, the source appears only in the FIQ pending word and never in the IRQ pending word.
- R5: The GPU routing register is at 0x0C: [1:0] is the IRQ target core, [3:2] the FIQ target core, bit 4 selects FIQ and bit 5 enables the GPU source. When enabled, the GPU interrupt sets pending bit 8 of exactly one core: the FIQ word of the FIQ target when bit 4 is set, otherwise the IRQ word of the IRQ target. It reads back as 6 bits.
- R6: Writing ones to bits [3:0] at 0x10 enables the PMU interrupt for those cores, and writing ones at 0x14 disables it. Zero bits leave the state unchanged. Both addresses read back the 4-bit enable mask. An enabled PMU interrupt sets IRQ pending bit 9 only.
- R7: The IRQ pending word of core c reads at 0x60+4c and the FIQ pending word at 0x70+4c. Bits 0-3 are timers 0-3, bits 4-7 are mailboxes 0-3, bit 8 is the GPU and bit 9 is the PMU. They follow the inputs in the same cycle, and writes to them are ignored.
- R8: `irq_o[c]` is the OR of core c's IRQ pending word, and `fiq_o[c]` is the OR of its FIQ pending word.
- R9: A write takes effect from the clock edge that accepts it, not earlier. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write byte address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read byte address |
| rd_data_o | output | 10 | Combinational read data |
| tmr_req_i | input | 16 | Timer requests, core c at [4c+3:4c] |
| mbx_act_i | input | 16 | Mailbox-active levels, core c at [4c+3:4c] |
| gpu_irq_i | input | 1 | Shared GPU interrupt |
| pmu_irq_i | input | 1 | PMU interrupt |
| irq_o | output | 4 | Per-core IRQ line |
| fiq_o | output | 4 | Per-core FIQ line |

## Verification
The bench goes after sources with both enables set. A design that ORs the enables instead of letting FIQ win would raise both lines for one event. It moves the GPU target among cores and flips the FIQ select. A faulty target decode would hit two cores or the wrong line. It interleaves PMU set and clear writes that carry zero bits, which would expose a plain store that wipes other cores' enables. It also writes to the pending and unmapped addresses and samples between a write's setup and its accepting edge, which catches a write-through register or aliased decoding.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int unsigned CORE_ID_W = 2;

  localparam int unsigned OFS_GPU_ROUTE = 'h0C;
  localparam int unsigned OFS_PMU_SET   = 'h10;
  localparam int unsigned OFS_PMU_CLR   = 'h14;
  localparam int unsigned OFS_TMR_CTL   = 'h40;
  localparam int unsigned OFS_MBX_CTL   = 'h50;
  localparam int unsigned OFS_IRQ_PEND  = 'h60;
  localparam int unsigned OFS_FIQ_PEND  = 'h70;
  localparam int unsigned CORE_STRIDE   = 4;

  typedef struct packed {
    logic                 en;
    logic                 fiq_mode;
    logic [CORE_ID_W-1:0] fiq_core;
    logic [CORE_ID_W-1:0] irq_core;
  } gpu_route_t;
endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned CTL_W  = 2 * N_LINES
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [CTL_W-1:0]                 wr_data_i,
  output logic [N_CORES-1:0][CTL_W-1:0]    tmr_ctl_o,
  output logic [N_CORES-1:0][CTL_W-1:0]    mbx_ctl_o,
  output logic [N_CORES-1:0]               pmu_en_o,
  output gpu_route_t                       gpu_route_o
);
  localparam int unsigned ROUTE_W = $bits(gpu_route_t);

  logic hit_gpu, hit_pset, hit_pclr;
  assign hit_gpu  = wr_en_i && (wr_addr_i == ADDR_W'(OFS_GPU_ROUTE));
  assign hit_pset = wr_en_i && (wr_addr_i == ADDR_W'(OFS_PMU_SET));
  assign hit_pclr = wr_en_i && (wr_addr_i == ADDR_W'(OFS_PMU_CLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpu_route_o <= '0;
    end else if (hit_gpu) begin
      gpu_route_o <= gpu_route_t'(wr_data_i[ROUTE_W-1:0]);
    end
  end

  // set/clear pair: zero bits keep state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmu_en_o <= '0;
    end else if (hit_pset) begin
      pmu_en_o <= pmu_en_o | wr_data_i[N_CORES-1:0];
    end else if (hit_pclr) begin
      pmu_en_o <= pmu_en_o & ~wr_data_i[N_CORES-1:0];
    end
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic hit_tmr, hit_mbx;
    assign hit_tmr = wr_en_i && (wr_addr_i == ADDR_W'(OFS_TMR_CTL + CORE_STRIDE * c));
    assign hit_mbx = wr_en_i && (wr_addr_i == ADDR_W'(OFS_MBX_CTL + CORE_STRIDE * c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tmr_ctl_o[c] <= '0;
      end else if (hit_tmr) begin
        tmr_ctl_o[c] <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mbx_ctl_o[c] <= '0;
      end else if (hit_mbx) begin
        mbx_ctl_o[c] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/lirq_core_route.sv
module lirq_core_route
  import lirq_pkg::*;
#(
  parameter int unsigned N_LINES = 4,
  parameter int unsigned CORE_ID = 0,
  localparam int unsigned CTL_W  = 2 * N_LINES,
  localparam int unsigned PEND_W = 2 * N_LINES + 2
) (
  input  logic [N_LINES-1:0] tmr_i,
  input  logic [N_LINES-1:0] mbx_i,
  input  logic [CTL_W-1:0]   tmr_ctl_i,
  input  logic [CTL_W-1:0]   mbx_ctl_i,
  input  logic               gpu_i,
  input  gpu_route_t         gpu_route_i,
  input  logic               pmu_i,
  input  logic               pmu_en_i,
  output logic [PEND_W-1:0]  irq_pend_o,
  output logic [PEND_W-1:0]  fiq_pend_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam logic [CORE_ID_W-1:0] MY_ID = CORE_ID_W'(CORE_ID);

  logic [N_LINES-1:0] tmr_irq_en, tmr_fiq_en, mbx_irq_en, mbx_fiq_en;
  logic               gpu_to_irq, gpu_to_fiq;

  // fast enable masks the normal one
  assign tmr_fiq_en = tmr_ctl_i[CTL_W-1:N_LINES];
  assign mbx_fiq_en = mbx_ctl_i[CTL_W-1:N_LINES];
  assign tmr_irq_en = tmr_ctl_i[N_LINES-1:0] & ~tmr_fiq_en;
  assign mbx_irq_en = mbx_ctl_i[N_LINES-1:0] & ~mbx_fiq_en;

  assign gpu_to_irq = gpu_route_i.en && !gpu_route_i.fiq_mode && (gpu_route_i.irq_core == MY_ID);
  assign gpu_to_fiq = gpu_route_i.en &&  gpu_route_i.fiq_mode && (gpu_route_i.fiq_core == MY_ID);

  assign irq_pend_o = {pmu_i & pmu_en_i, gpu_i & gpu_to_irq,
                       mbx_i & mbx_irq_en, tmr_i & tmr_irq_en};
  assign fiq_pend_o = {1'b0, gpu_i & gpu_to_fiq,
                       mbx_i & mbx_fiq_en, tmr_i & tmr_fiq_en};

  assign irq_o = |irq_pend_o;
  assign fiq_o = |fiq_pend_o;
endmodule

// File: rtl/lirq_rd_mux.sv
module lirq_rd_mux
  import lirq_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned CTL_W  = 2 * N_LINES,
  localparam int unsigned PEND_W = 2 * N_LINES + 2
) (
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic [N_CORES-1:0][CTL_W-1:0]  tmr_ctl_i,
  input  logic [N_CORES-1:0][CTL_W-1:0]  mbx_ctl_i,
  input  logic [N_CORES-1:0]             pmu_en_i,
  input  gpu_route_t                     gpu_route_i,
  input  logic [N_CORES-1:0][PEND_W-1:0] irq_pend_i,
  input  logic [N_CORES-1:0][PEND_W-1:0] fiq_pend_i,
  output logic [PEND_W-1:0]              rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(OFS_GPU_ROUTE)) rd_data_o = PEND_W'(gpu_route_i);
    if (rd_addr_i == ADDR_W'(OFS_PMU_SET) || rd_addr_i == ADDR_W'(OFS_PMU_CLR))
      rd_data_o = PEND_W'(pmu_en_i);
    for (int c = 0; c < N_CORES; c++) begin
      if (rd_addr_i == ADDR_W'(OFS_TMR_CTL + CORE_STRIDE * c)) rd_data_o = PEND_W'(tmr_ctl_i[c]);
      if (rd_addr_i == ADDR_W'(OFS_MBX_CTL + CORE_STRIDE * c)) rd_data_o = PEND_W'(mbx_ctl_i[c]);
      if (rd_addr_i == ADDR_W'(OFS_IRQ_PEND + CORE_STRIDE * c)) rd_data_o = irq_pend_i[c];
      if (rd_addr_i == ADDR_W'(OFS_FIQ_PEND + CORE_STRIDE * c)) rd_data_o = fiq_pend_i[c];
    end
  end
endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned CTL_W  = 2 * N_LINES,
  localparam int unsigned PEND_W = 2 * N_LINES + 2,
  localparam int unsigned SRC_W  = N_CORES * N_LINES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CTL_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [PEND_W-1:0]  rd_data_o,
  input  logic [SRC_W-1:0]   tmr_req_i,
  input  logic [SRC_W-1:0]   mbx_act_i,
  input  logic               gpu_irq_i,
  input  logic               pmu_irq_i,
  output logic [N_CORES-1:0] irq_o,
  output logic [N_CORES-1:0] fiq_o
);
  logic [N_CORES-1:0][CTL_W-1:0]  tmr_ctl, mbx_ctl;
  logic [N_CORES-1:0]             pmu_en;
  gpu_route_t                     gpu_route;
  logic [N_CORES-1:0][PEND_W-1:0] irq_pend, fiq_pend;

  lirq_regs #(.N_CORES(N_CORES), .N_LINES(N_LINES), .ADDR_W(ADDR_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .tmr_ctl_o   (tmr_ctl),
    .mbx_ctl_o   (mbx_ctl),
    .pmu_en_o    (pmu_en),
    .gpu_route_o (gpu_route)
  );

  for (genvar c = 0; c < N_CORES; c++) begin : g_route
    lirq_core_route #(.N_LINES(N_LINES), .CORE_ID(c)) i_route (
      .tmr_i       (tmr_req_i[c*N_LINES +: N_LINES]),
      .mbx_i       (mbx_act_i[c*N_LINES +: N_LINES]),
      .tmr_ctl_i   (tmr_ctl[c]),
      .mbx_ctl_i   (mbx_ctl[c]),
      .gpu_i       (gpu_irq_i),
      .gpu_route_i (gpu_route),
      .pmu_i       (pmu_irq_i),
      .pmu_en_i    (pmu_en[c]),
      .irq_pend_o  (irq_pend[c]),
      .fiq_pend_o  (fiq_pend[c]),
      .irq_o       (irq_o[c]),
      .fiq_o       (fiq_o[c])
    );
  end

  lirq_rd_mux #(.N_CORES(N_CORES), .N_LINES(N_LINES), .ADDR_W(ADDR_W)) i_rd_mux (
    .rd_addr_i   (rd_addr_i),
    .tmr_ctl_i   (tmr_ctl),
    .mbx_ctl_i   (mbx_ctl),
    .pmu_en_i    (pmu_en),
    .gpu_route_i (gpu_route),
    .irq_pend_i  (irq_pend),
    .fiq_pend_i  (fiq_pend),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/lirq_router_chk.sv
module lirq_router_chk
  import lirq_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_LINES = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned CTL_W  = 2 * N_LINES,
  localparam int unsigned PEND_W = 2 * N_LINES + 2,
  localparam int unsigned ROUTE_W = $bits(gpu_route_t)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic [ADDR_W-1:0]                wr_addr_i,
  input logic [N_CORES-1:0]               pmu_wd,
  input logic [N_CORES-1:0]               irq_o,
  input logic [N_CORES-1:0]               fiq_o,
  input logic [N_CORES-1:0]               pmu_en,
  input logic [N_CORES-1:0][CTL_W-1:0]    tmr_ctl,
  input logic [N_CORES-1:0][CTL_W-1:0]    mbx_ctl,
  input logic [ROUTE_W-1:0]               gpu_route,
  input logic [N_CORES-1:0][PEND_W-1:0]   irq_pend,
  input logic [N_CORES-1:0][PEND_W-1:0]   fiq_pend
);
  localparam int unsigned GPU_BIT = 2 * N_LINES;

  logic                   cfg_zero;
  logic [2*N_CORES-1:0]   gpu_hits;

  assign cfg_zero = (tmr_ctl == '0) && (mbx_ctl == '0) && (pmu_en == '0) && (gpu_route == '0);

  assert_quiet_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_zero |-> (irq_o == '0 && fiq_o == '0));

  assert_pmu_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(OFS_PMU_SET)) |=>
      (pmu_en == ($past(pmu_en) | $past(pmu_wd))));

  assert_pmu_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(OFS_PMU_CLR)) |=>
      (pmu_en == ($past(pmu_en) & ~$past(pmu_wd))));

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    assign gpu_hits[2*c]   = irq_pend[c][GPU_BIT];
    assign gpu_hits[2*c+1] = fiq_pend[c][GPU_BIT];

    assert_fiq_override_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_pend[c][GPU_BIT-1:0] & fiq_pend[c][GPU_BIT-1:0]) == '0);

    assert_irq_or_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] == (irq_pend[c] != '0));

    assert_fiq_or_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fiq_o[c] == (fiq_pend[c] != '0));
  end

  assert_gpu_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gpu_hits));
endmodule

bind lirq_router lirq_router_chk #(
  .N_CORES(N_CORES), .N_LINES(N_LINES), .ADDR_W(ADDR_W)
) i_lirq_router_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .pmu_wd    (wr_data_i[N_CORES-1:0]),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .pmu_en    (pmu_en),
  .tmr_ctl   (tmr_ctl),
  .mbx_ctl   (mbx_ctl),
  .gpu_route (gpu_route),
  .irq_pend  (irq_pend),
  .fiq_pend  (fiq_pend)
);

// File: tb/test_lirq_router.sv
`timescale 1ns/1ps
module test_lirq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [7:0]  rd_addr_i = '0;
  logic [9:0]  rd_data_o;
  logic [15:0] tmr_req_i = '0;
  logic [15:0] mbx_act_i = '0;
  logic        gpu_irq_i = 1'b0;
  logic        pmu_irq_i = 1'b0;
  logic [3:0]  irq_o, fiq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_tctl [4];
  logic [7:0] m_mctl [4];
  logic [3:0] m_pmu;
  logic [5:0] m_gpu;

  always #2.5 clk_i = ~clk_i;

  lirq_router i_lirq_router (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .tmr_req_i, .mbx_act_i, .gpu_irq_i, .pmu_irq_i, .irq_o, .fiq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] exp_irq(input int c);
    logic [3:0] t, m;
    logic [7:0] tc, mc;
    t = tmr_req_i[4*c +: 4]; m = mbx_act_i[4*c +: 4];
    tc = m_tctl[c]; mc = m_mctl[c];
    return {pmu_irq_i & m_pmu[c],
            gpu_irq_i & m_gpu[5] & ~m_gpu[4] & (m_gpu[1:0] == 2'(c)),
            m & mc[3:0] & ~mc[7:4], t & tc[3:0] & ~tc[7:4]};
  endfunction

  function automatic logic [9:0] exp_fiq(input int c);
    logic [3:0] t, m;
    t = tmr_req_i[4*c +: 4]; m = mbx_act_i[4*c +: 4];
    return {1'b0, gpu_irq_i & m_gpu[5] & m_gpu[4] & (m_gpu[3:2] == 2'(c)),
            m & m_mctl[c][7:4], t & m_tctl[c][7:4]};
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h0C) m_gpu = d[5:0];
    else if (a == 8'h10) m_pmu = m_pmu | d[3:0];
    else if (a == 8'h14) m_pmu = m_pmu & ~d[3:0];
    else if (a >= 8'h40 && a <= 8'h4C && a[1:0] == 2'b00) m_tctl[a[3:2]] = d;
    else if (a >= 8'h50 && a <= 8'h5C && a[1:0] == 2'b00) m_mctl[a[3:2]] = d;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [9:0] exp);
    rd_addr_i = a;
    #1;
    chk(req, 32'(rd_data_o), 32'(exp));
  endtask

  // full observation: lines, pending words, control readback
  task automatic check_all();
    #1;
    for (int c = 0; c < 4; c++) begin
      chk("R8 irq_o", 32'(irq_o[c]), 32'(|exp_irq(c)));
      chk("R8 fiq_o", 32'(fiq_o[c]), 32'(|exp_fiq(c)));
      rd_chk("R7 irq pending", 8'(8'h60 + 4*c), exp_irq(c));
      rd_chk("R7 fiq pending", 8'(8'h70 + 4*c), exp_fiq(c));
      rd_chk("R2 timer ctl", 8'(8'h40 + 4*c), 10'(m_tctl[c]));
      rd_chk("R3 mailbox ctl", 8'(8'h50 + 4*c), 10'(m_mctl[c]));
    end
    rd_chk("R5 gpu route", 8'h0C, 10'(m_gpu));
    rd_chk("R6 pmu set view", 8'h10, 10'(m_pmu));
    rd_chk("R6 pmu clr view", 8'h14, 10'(m_pmu));
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [16];
    addrs = '{8'h0C, 8'h10, 8'h14, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50,
              8'h54, 8'h58, 8'h5C, 8'h60, 8'h74, 8'h00, 8'h42, 8'h20};
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin m_tctl[c] = '0; m_mctl[c] = '0; end
    m_pmu = '0; m_gpu = '0;

    // R1: reset with all sources active
    tmr_req_i = '1; mbx_act_i = '1; gpu_irq_i = 1'b1; pmu_irq_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 irq_o quiet", 32'(irq_o), 32'h0);
    chk("R1 fiq_o quiet", 32'(fiq_o), 32'h0);
    check_all();

    // R7: pending words ignore writes
    wr(8'h60, 8'hFF); wr(8'h7C, 8'hFF);
    check_all();

    // R9: unmapped reads zero
    rd_chk("R9 unmapped 0x04", 8'h04, 10'h0);
    rd_chk("R9 unmapped 0x80", 8'h80, 10'h0);
    rd_chk("R9 unaligned 0x41", 8'h41, 10'h0);

    // R2: core1 timers onto IRQ
    tmr_req_i = 16'h00A0; mbx_act_i = '0; gpu_irq_i = 1'b0; pmu_irq_i = 1'b0;
    wr(8'h44, 8'h0F);
    rd_chk("R2 core1 timer irq", 8'h64, 10'h00A);
    check_all();

    // R4: both enables -> FIQ only
    wr(8'h44, 8'hFF);
    rd_chk("R4 irq empty", 8'h64, 10'h000);
    rd_chk("R4 fiq holds", 8'h74, 10'h00A);
    check_all();

    // R3: core2 mailboxes split IRQ/FIQ
    mbx_act_i = 16'h0F00;
    wr(8'h58, 8'hC3);
    rd_chk("R3 core2 mbx irq", 8'h68, 10'h030);
    rd_chk("R3 core2 mbx fiq", 8'h78, 10'h0C0);
    check_all();

    // R5: GPU to core2 IRQ, then core3 FIQ, then disabled
    tmr_req_i = '0; mbx_act_i = '0; gpu_irq_i = 1'b1;
    wr(8'h0C, 8'h22);
    rd_chk("R5 gpu irq core2", 8'h68, 10'h100);
    check_all();
    wr(8'h0C, 8'h3E);
    rd_chk("R5 gpu fiq core3", 8'h7C, 10'h100);
    rd_chk("R5 gpu not irq core2", 8'h68, 10'h000);
    check_all();
    wr(8'h0C, 8'h1E);
    chk("R5 gpu disabled", 32'({irq_o, fiq_o}), 32'h0);
    check_all();

    // R6: PMU set/clear with zero bits preserved
    gpu_irq_i = 1'b0; pmu_irq_i = 1'b1;
    wr(8'h10, 8'h0A);
    rd_chk("R6 pmu mask A", 8'h10, 10'h00A);
    wr(8'h10, 8'h01);
    rd_chk("R6 pmu mask B", 8'h14, 10'h00B);
    wr(8'h14, 8'h02);
    rd_chk("R6 pmu mask 9", 8'h10, 10'h009);
    chk("R6 pmu irq lines", 32'(irq_o), 32'h9);
    chk("R6 pmu never fiq", 32'(fiq_o), 32'h0);
    check_all();

    // R9: write not visible before accepting edge
    pmu_irq_i = 1'b0; tmr_req_i = 16'h0100;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 8'h48; wr_data_i = 8'h01;
    #1;
    chk("R9 before edge", 32'(irq_o[2]), 32'h0);
    @(posedge clk_i);
    #1;
    chk("R9 after edge", 32'(irq_o[2]), 32'h1);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model_write(8'h48, 8'h01);
    check_all();

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = addrs[$urandom_range(0, 15)];
      tmr_req_i = 16'($urandom); mbx_act_i = 16'($urandom);
      gpu_irq_i = 1'($urandom); pmu_irq_i = 1'($urandom);
      wr(a, 8'($urandom));
      check_all();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule